// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Entry Lockdown

This block caches virtual-to-physical translations for a processor's memory system. It has 32 entries, and any translation may sit in any entry. Each entry records the physical page frame, a page-size code, an access-permission field and a set of region attribute bits (cacheable, bufferable, write policy and similar). A lookup presents a 32-bit virtual address and gets back a registered hit or miss, the physical address, the permissions and the attributes one clock later. On a miss, an external walker (played by the bench) resolves the translation and writes it back through the refill port.

Before any tag compare, an address whose top seven bits are all zero is relocated into a per-process slot: those bits are replaced by the current process identifier. Four page sizes are matched side by side: 1 MB sections, 64 KB large pages, 4 KB small pages and 1 KB tiny pages.

Entries can be pinned, and a pinned entry is never replaced. A maintenance port can flush the whole table, which spares the pinned entries, or it can drop, pin or unpin the entries that match one address. When translation is switched off, every lookup hits with the physical address equal to the virtual one and with fixed default permissions and attributes.

Top module: `tlb_cam`

## Requirements
- R1: The table holds 32 entries. After 32 refills of distinct pages into an empty table, all 32 pages hit at once.
- R2: `lk_valid` rises exactly one cycle after `lk_req`, together with exactly one of `lk_hit` or `lk_miss`. On a hit, `lk_perm` and `lk_attr` are the values stored with the matching entry. On a miss, `lk_paddr` is zero.
- R3: Page-size code 0 is a 1 MB section, 1 is a 64 KB page, 2 is a 4 KB page and 3 is a 1 KB page. The tag compare ignores the virtual bits below the page size. `lk_paddr` takes its bits above the page size from the stored frame and its bits below from the virtual address.
- R4: A refill goes to the lowest-indexed entry that is both invalid and unpinned. If there is none, it goes to the first unpinned entry found by scanning upward (with wrap) from a pointer. The pointer starts at 0 after reset and moves to one past each refilled entry. If all entries are pinned, the refill is dropped and `rf_drop` is high for one cycle, starting on the cycle after the refill.
- R5: An entry is pinned when it is refilled with `rf_lock`=1 or when it matches a pin operation (`ctl_op`=3). An unpin operation (`ctl_op`=4) releases it. A pinned entry survives both replacement and flush-all.
- R6: When virtual address bits [31:25] are all zero, they are replaced by `pid` before the compare. This remap applies to lookups, refills and maintenance addresses alike. Addresses with any of those bits set are compared unchanged.
- R7: With `xlate_en`=0, a lookup hits with `lk_paddr` equal to `lk_vaddr`, permission all ones, attribute zero, and `lk_multi`=0.
- R8: Flush-all (`ctl_op`=1) invalidates every unpinned entry and leaves the pinned ones valid.
- R9: Flush-by-address (`ctl_op`=2) invalidates every entry matching the address, pinned or not, and clears its pin.
- R10: When several entries match, the lowest-indexed one supplies the result and `lk_multi` is set. `lk_multi` is clear when exactly one entry matches.
- R11: A refill issued in the same cycle as any maintenance operation (`ctl_op`≠0) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlate_en | input | 1 | Translation enable; 0 selects bypass |
| pid | input | 7 | Process identifier used for relocation |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_multi | output | 1 | More than one entry matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm | output | 2 | Access permissions of the hit |
| lk_attr | output | 6 | Region attributes of the hit |
| rf_we | input | 1 | Refill write strobe |
| rf_vtag | input | 22 | Refill virtual address bits [31:10] |
| rf_size | input | 2 | Refill page-size code |
| rf_ptag | input | 22 | Refill physical address bits [31:10] |
| rf_perm | input | 2 | Refill permissions |
| rf_attr | input | 6 | Refill attributes |
| rf_lock | input | 1 | Pin the refilled entry |
| rf_drop | output | 1 | Refill discarded because every entry is pinned |
| ctl_op | input | 3 | 0 none, 1 flush all, 2 flush address, 3 pin address, 4 unpin address |
| ctl_vtag | input | 22 | Maintenance virtual address bits [31:10] |

## Verification
A wrong valid or pin bit shows up on the next lookup of the affected page, as a miss where a hit was due or as a stale hit after a flush. A bad replacement pointer shows up one refill later, when a different resident page disappears than the one the scan order predicts. A mask or size-code error changes `lk_paddr` for offsets near a page boundary, or it turns the neighbouring page into a false hit. All of these appear in the result of the first lookup issued after the faulty update, one cycle after the request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W    = 32;
  localparam int TAG_LSB = 10;
  localparam int TAG_W   = VA_W - TAG_LSB;
  localparam int PID_W   = 7;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } pg_size_e;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_INV_ALL   = 3'd1,
    OP_INV_VA    = 3'd2,
    OP_LOCK_VA   = 3'd3,
    OP_UNLOCK_VA = 3'd4
  } ctl_op_e;

  // ones on the tag bits that take part in the compare
  function automatic logic [TAG_W-1:0] tag_mask(input pg_size_e sz);
    case (sz)
      PG_SECTION: tag_mask = {{(TAG_W-10){1'b1}}, 10'b0};
      PG_LARGE:   tag_mask = {{(TAG_W-6){1'b1}}, 6'b0};
      PG_SMALL:   tag_mask = {{(TAG_W-2){1'b1}}, 2'b0};
      default:    tag_mask = '1;
    endcase
  endfunction

  // relocate low addresses into the process slot
  function automatic logic [TAG_W-1:0] remap_tag(input logic [TAG_W-1:0] vt,
                                                 input logic [PID_W-1:0] id);
    if (vt[TAG_W-1 -: PID_W] == '0) remap_tag = {id, vt[TAG_W-PID_W-1:0]};
    else remap_tag = vt;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [TAG_W-1:0]   vtag_i [ENTRIES],
  input  pg_size_e           size_i [ENTRIES],
  output logic [ENTRIES-1:0] match_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [TAG_W-1:0] m;
    assign m = tag_mask(size_i[e]);
    assign match_o[e] = valid_i[e] && ((tag_i & m) == (vtag_i[e] & m));
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     locked_i,
  input  logic [IDX_W-1:0] rr_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] victim_o
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             rot_ok;
  logic [IDX_W-1:0] rot_idx;

  tlb_prio #(.N(N), .IDX_W(IDX_W)) i_free (
    .req_i(~valid_i & ~locked_i), .found_o(free_found), .idx_o(free_idx));

  always_comb begin
    int j;
    rot_ok  = 1'b0;
    rot_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      j = int'(rr_i) + k;
      if (j >= N) j = j - N;
      if (!locked_i[j]) begin
        rot_ok  = 1'b1;
        rot_idx = IDX_W'(j);
      end
    end
  end

  assign ok_o     = free_found | rot_ok;
  assign victim_o = free_found ? free_idx : rot_idx;

  always_comb begin
    if (ok_o) a_r4_victim_unlocked: assert (!locked_i[victim_o]);
    if (|(~valid_i & ~locked_i)) a_r4_free_first: assert (!valid_i[victim_o]);
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PERM_W  = 2,
  parameter int ATTR_W  = 6,
  parameter logic [PERM_W-1:0] BYPASS_PERM = '1,
  parameter logic [ATTR_W-1:0] BYPASS_ATTR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlate_en,
  input  logic [6:0]        pid,
  input  logic              lk_req,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [31:0]       lk_paddr,
  output logic [PERM_W-1:0] lk_perm,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              rf_we,
  input  logic [21:0]       rf_vtag,
  input  logic [1:0]        rf_size,
  input  logic [21:0]       rf_ptag,
  input  logic [PERM_W-1:0] rf_perm,
  input  logic [ATTR_W-1:0] rf_attr,
  input  logic              rf_lock,
  output logic              rf_drop,
  input  logic [2:0]        ctl_op,
  input  logic [21:0]       ctl_vtag
);
  localparam int IDX_W = $clog2(ENTRIES);

  // entry payload: written only by refill, no reset
  logic [TAG_W-1:0]  vtag_q [ENTRIES];
  logic [TAG_W-1:0]  ptag_q [ENTRIES];
  pg_size_e          size_q [ENTRIES];
  logic [PERM_W-1:0] perm_q [ENTRIES];
  logic [ATTR_W-1:0] attr_q [ENTRIES];
  // per-entry state bits
  logic [ENTRIES-1:0] valid_q, lock_q;
  logic [IDX_W-1:0]   rr_q;

  logic [TAG_W-1:0]   lk_tag, rf_tag, ctl_tag;
  logic [ENTRIES-1:0] lk_match, ctl_match;
  logic               hit_found, victim_ok, rf_take;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic [TAG_W-1:0]   hit_mask;

  assign lk_tag  = remap_tag(lk_vaddr[VA_W-1:TAG_LSB], pid);
  assign rf_tag  = remap_tag(rf_vtag, pid);
  assign ctl_tag = remap_tag(ctl_vtag, pid);

  tlb_match #(.ENTRIES(ENTRIES)) i_lk_match (
    .tag_i(lk_tag), .valid_i(valid_q), .vtag_i(vtag_q), .size_i(size_q),
    .match_o(lk_match));

  tlb_match #(.ENTRIES(ENTRIES)) i_ctl_match (
    .tag_i(ctl_tag), .valid_i(valid_q), .vtag_i(vtag_q), .size_i(size_q),
    .match_o(ctl_match));

  tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) i_hit_prio (
    .req_i(lk_match), .found_o(hit_found), .idx_o(hit_idx));

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .valid_i(valid_q), .locked_i(lock_q), .rr_i(rr_q),
    .ok_o(victim_ok), .victim_o(victim));

  assign hit_mask = tag_mask(size_q[hit_idx]);
  assign rf_take  = rf_we && (ctl_op == OP_NONE) && victim_ok;

  // lookup result register
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid <= 1'b0; lk_hit <= 1'b0; lk_miss <= 1'b0; lk_multi <= 1'b0;
      lk_paddr <= '0;   lk_perm <= '0;  lk_attr <= '0;
    end else begin
      lk_valid <= lk_req;
      if (lk_req && !xlate_en) begin
        lk_hit <= 1'b1; lk_miss <= 1'b0; lk_multi <= 1'b0;
        lk_paddr <= lk_vaddr; lk_perm <= BYPASS_PERM; lk_attr <= BYPASS_ATTR;
      end else if (lk_req && hit_found) begin
        lk_hit   <= 1'b1;
        lk_miss  <= 1'b0;
        lk_multi <= ($countones(lk_match) > 1);
        lk_paddr <= {(ptag_q[hit_idx] & hit_mask) | (lk_tag & ~hit_mask),
                     lk_vaddr[TAG_LSB-1:0]};
        lk_perm  <= perm_q[hit_idx];
        lk_attr  <= attr_q[hit_idx];
      end else begin
        lk_hit <= 1'b0; lk_miss <= lk_req; lk_multi <= 1'b0;
        lk_paddr <= '0; lk_perm <= '0; lk_attr <= '0;
      end
    end
  end

  // payload write port
  always_ff @(posedge clk) begin
    if (rf_take) begin
      vtag_q[victim] <= rf_tag;
      ptag_q[victim] <= rf_ptag;
      size_q[victim] <= pg_size_e'(rf_size);
      perm_q[victim] <= rf_perm;
      attr_q[victim] <= rf_attr;
    end
  end

  // valid, pin and replacement pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0; lock_q <= '0; rr_q <= '0; rf_drop <= 1'b0;
    end else begin
      rf_drop <= rf_we && (ctl_op == OP_NONE) && !victim_ok;
      case (ctl_op)
        OP_INV_ALL:   valid_q <= valid_q & lock_q;
        OP_INV_VA: begin
          valid_q <= valid_q & ~ctl_match;
          lock_q  <= lock_q & ~ctl_match;
        end
        OP_LOCK_VA:   lock_q <= lock_q | ctl_match;
        OP_UNLOCK_VA: lock_q <= lock_q & ~ctl_match;
        default: if (rf_take) begin
          valid_q[victim] <= 1'b1;
          lock_q[victim]  <= rf_lock;
          rr_q <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
        end
      endcase
    end
  end

  a_r5_lock_implies_valid: assert property (@(posedge clk) disable iff (rst)
    (lock_q & ~valid_q) == '0);
  a_r4_drop_all_locked: assert property (@(posedge clk) disable iff (rst)
    (rf_we && ctl_op == OP_NONE && (&lock_q)) |=> rf_drop);
  a_r8_flush_spares_pinned: assert property (@(posedge clk) disable iff (rst)
    (ctl_op == OP_INV_ALL) |=> ((valid_q & ~lock_q) == '0) && (lock_q == $past(lock_q)));
  a_r7_bypass_identity: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !xlate_en) |=> lk_hit && (lk_paddr == $past(lk_vaddr)) && (lk_attr == BYPASS_ATTR));
  a_r10_multi_needs_hit: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid && (lk_hit != lk_miss));
endmodule

// File: tb/test_tlb_cam.sv
module test_tlb_cam;
  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic xlate_en = 1'b1;
  logic [6:0] pid = '0;
  logic lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic lk_valid, lk_hit, lk_miss, lk_multi;
  logic [31:0] lk_paddr;
  logic [1:0] lk_perm;
  logic [5:0] lk_attr;
  logic rf_we = 1'b0, rf_lock = 1'b0;
  logic [21:0] rf_vtag = '0, rf_ptag = '0, ctl_vtag = '0;
  logic [1:0] rf_size = '0, rf_perm = '0;
  logic [5:0] rf_attr = '0;
  logic rf_drop;
  logic [2:0] ctl_op = '0;
  int checks = 0, errors = 0;
  logic drop_seen;

  tlb_cam i_tlb_cam (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refill(input logic [31:0] va, input logic [1:0] sz, input logic [31:0] pa,
                        input logic [1:0] pm, input logic [5:0] at, input logic lk,
                        input logic [2:0] op);
    @(negedge clk);
    rf_we = 1'b1; rf_vtag = va[31:10]; rf_size = sz; rf_ptag = pa[31:10];
    rf_perm = pm; rf_attr = at; rf_lock = lk; ctl_op = op; ctl_vtag = va[31:10];
    @(negedge clk);
    rf_we = 1'b0; ctl_op = 3'd0; drop_seen = rf_drop;
  endtask

  task automatic ctl(input logic [2:0] op, input logic [31:0] va);
    @(negedge clk);
    ctl_op = op; ctl_vtag = va[31:10];
    @(negedge clk);
    ctl_op = 3'd0;
  endtask

  task automatic look(input logic [31:0] va);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input logic [31:0] pa,
                            input logic [1:0] pm, input logic [5:0] at);
    look(va);
    check(req, {lk_valid, lk_hit, lk_miss, lk_paddr, lk_perm, lk_attr},
               {1'b1, 1'b1, 1'b0, pa, pm, at});
  endtask

  task automatic expect_miss(input string req, input logic [31:0] va);
    look(va);
    check(req, {lk_valid, lk_hit, lk_miss, lk_paddr}, {1'b1, 1'b0, 1'b1, 32'h0});
  endtask

  function automatic logic [31:0] pva(input int i);
    return 32'h0200_0000 | (i << 12);
  endfunction
  function automatic logic [31:0] ppa(input int i);
    return 32'h4000_0000 | (i << 12);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R2 reset outputs", {lk_valid, lk_hit, lk_miss, rf_drop}, 4'b0);
    expect_miss("R2 empty table", pva(0));

    // R1: fill all entries with small pages
    for (int i = 0; i < 32; i++) begin
      refill(pva(i), 2'd2, ppa(i), 2'(i), 6'(i), 1'b0, 3'd0);
      check("R4 no drop on free entry", drop_seen, 1'b0);
    end
    for (int i = 0; i < 32; i++)
      expect_hit("R1 all resident", pva(i) | 32'hABC, ppa(i) | 32'hABC, 2'(i), 6'(i));
    look(pva(5));
    check("R10 single match no multi", lk_multi, 1'b0);
    expect_miss("R2 unmapped page", pva(40));

    // R4/R5: pin 0 and 1, then replace in round-robin order
    ctl(3'd3, pva(0));
    ctl(3'd3, pva(1));
    refill(32'h0300_0000, 2'd2, 32'h5000_0000, 2'd1, 6'h11, 1'b0, 3'd0);
    expect_miss("R4 entry 2 replaced", pva(2));
    expect_hit("R5 pinned 0 kept", pva(0), ppa(0), 2'd0, 6'd0);
    expect_hit("R4 new page", 32'h0300_0010, 32'h5000_0010, 2'd1, 6'h11);
    refill(32'h0300_1000, 2'd2, 32'h5000_1000, 2'd2, 6'h12, 1'b0, 3'd0);
    expect_miss("R4 entry 3 replaced", pva(3));
    expect_hit("R4 entry 4 kept", pva(4), ppa(4), 2'd0, 6'd4);

    // R8: flush all spares pinned entries
    ctl(3'd1, 32'h0);
    expect_hit("R8 pinned 0 survives", pva(0), ppa(0), 2'd0, 6'd0);
    expect_hit("R8 pinned 1 survives", pva(1), ppa(1), 2'd1, 6'd1);
    expect_miss("R8 unpinned flushed", pva(4));
    expect_miss("R8 new page flushed", 32'h0300_0000);

    // R9: flush by address removes a pinned entry
    refill(pva(7), 2'd2, ppa(7), 2'd3, 6'h07, 1'b0, 3'd0);
    expect_hit("R4 refill into free entry", pva(7), ppa(7), 2'd3, 6'h07);
    ctl(3'd2, pva(0));
    expect_miss("R9 pinned entry dropped", pva(0));
    expect_hit("R9 other pinned kept", pva(1), ppa(1), 2'd1, 6'd1);
    ctl(3'd4, pva(1));
    ctl(3'd1, 32'h0);
    expect_miss("R5 unpinned then flushed", pva(1));

    // R11: refill together with maintenance is ignored
    refill(pva(9), 2'd2, ppa(9), 2'd0, 6'h09, 1'b0, 3'd1);
    expect_miss("R11 refill ignored", pva(9));

    // R3: page sizes
    refill(32'h0530_0000, 2'd0, 32'h8000_0000, 2'd1, 6'h21, 1'b0, 3'd0);
    expect_hit("R3 section", 32'h053A_BCDE, 32'h800A_BCDE, 2'd1, 6'h21);
    expect_miss("R3 section neighbour", 32'h0540_0000);
    refill(32'h0600_0000, 2'd1, 32'h9000_0000, 2'd2, 6'h22, 1'b0, 3'd0);
    expect_hit("R3 large", 32'h0600_F123, 32'h9000_F123, 2'd2, 6'h22);
    expect_miss("R3 large neighbour", 32'h0601_0000);
    refill(32'h0700_0400, 2'd3, 32'hA000_0800, 2'd3, 6'h23, 1'b0, 3'd0);
    expect_hit("R3 tiny", 32'h0700_07FF, 32'hA000_0BFF, 2'd3, 6'h23);
    expect_miss("R3 tiny neighbour", 32'h0700_0800);
    expect_miss("R3 tiny below", 32'h0700_03FF);

    // R6: process relocation
    pid = 7'h05;
    refill(32'h0000_3000, 2'd2, 32'hB000_0000, 2'd1, 6'h30, 1'b0, 3'd0);
    expect_hit("R6 relocated lookup", 32'h0000_3456, 32'hB000_0456, 2'd1, 6'h30);
    expect_hit("R6 explicit slot", 32'h0A00_3456, 32'hB000_0456, 2'd1, 6'h30);
    pid = 7'h06;
    expect_miss("R6 other process", 32'h0000_3456);
    pid = 7'h00;

    // R7: bypass
    xlate_en = 1'b0;
    expect_hit("R7 bypass unmapped", 32'h1234_5678, 32'h1234_5678, 2'b11, 6'h00);
    expect_hit("R7 bypass mapped", 32'h0600_F123, 32'h0600_F123, 2'b11, 6'h00);
    check("R7 bypass no multi", lk_multi, 1'b0);
    xlate_en = 1'b1;

    // R10: overlapping entries, lowest index wins
    ctl(3'd1, 32'h0);
    refill(32'h0C00_0000, 2'd2, 32'hC000_0000, 2'd1, 6'h01, 1'b0, 3'd0);
    refill(32'h0C00_0000, 2'd0, 32'hD000_0000, 2'd2, 6'h02, 1'b0, 3'd0);
    expect_hit("R10 lowest index wins", 32'h0C00_0123, 32'hC000_0123, 2'd1, 6'h01);
    check("R10 multi flag", lk_multi, 1'b1);
    expect_hit("R10 single match", 32'h0C01_0000, 32'hD001_0000, 2'd2, 6'h02);
    check("R10 multi clear", lk_multi, 1'b0);

    // R4: every entry pinned, refill dropped
    ctl(3'd1, 32'h0);
    for (int i = 0; i < 32; i++) refill(pva(i), 2'd2, ppa(i), 2'd0, 6'h3F, 1'b1, 3'd0);
    refill(pva(50), 2'd2, ppa(50), 2'd0, 6'h00, 1'b0, 3'd0);
    check("R4 drop flag", drop_seen, 1'b1);
    @(negedge clk);
    check("R4 drop one cycle", rf_drop, 1'b0);
    expect_miss("R4 dropped page absent", pva(50));
    expect_hit("R5 pinned first", pva(0), ppa(0), 2'd0, 6'h3F);
    expect_hit("R5 pinned last", pva(31), ppa(31), 2'd0, 6'h3F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule